// File: doc/BRIEF.md
# Offset-Range Synchronous Counter

A synchronous binary up-counter built from cascaded fixed-width stages. Each stage has a synchronous clear, a synchronous parallel load and two count enables. A stage advances only when both of its enables are high. Its carry output is high when the stage holds all ones and its carry-in enable is high. Stages are chained so that the carry of one stage is the second enable of the next stage.

A wrap controller around the chain confines counting to a range. In start-offset mode the overall carry triggers a reload of a programmable start value, so the count runs from that value up to all ones and then repeats. In end-offset mode, matching the count against a programmable end value triggers a synchronous clear, so the count runs from zero up to that value and then repeats. Both wrap actions act on the next rising clock edge and only while both enables are high.

Top module: `offset_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is zero.
- R2: When `en_p_i` and `en_t_i` are both high and no wrap condition applies, `count_o` increases by one on the next rising edge.
- R3: When either enable is low, `count_o` keeps its value on the next edge, including at the all-ones value and at the end value, so no reload and no clear happen.
- R4: `carry_o` is high exactly when `en_t_i` is high and `count_o` is all ones. It is combinational and does not depend on `en_p_i`.
- R5: With `mode_i` = 0 (start-offset), both enables high and `count_o` all ones, the next edge loads `start_val_i` into the count.
- R6: With `mode_i` = 1 (end-offset), both enables high and `count_o` equal to `end_val_i`, the next edge clears the count to zero.
- R7: Stages cascade. A higher stage advances only on edges where every lower stage is at all ones, so the count carries across stage boundaries (for example 0x0F to 0x10).
- R8: Outside the range, counting continues normally. In start-offset mode a count below the start value counts up. In end-offset mode a count above the end value counts up to all ones and then rolls over to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_p_i | input | 1 | Count enable; it does not affect the carry |
| en_t_i | input | 1 | Count enable; it also gates the carry |
| mode_i | input | 1 | Wrap mode: 0 = reload start value, 1 = clear at end value |
| start_val_i | input | STAGE_W*NUM_STAGES | Value loaded after all ones in start-offset mode |
| end_val_i | input | STAGE_W*NUM_STAGES | Last value before the clear in end-offset mode |
| count_o | output | STAGE_W*NUM_STAGES | Current count |
| carry_o | output | 1 | Carry: `en_t_i` AND count all ones |

## Verification
The bench builds the counter with two 4-bit stages, giving an 8-bit count. This brings the stage-to-stage carry chain into reach, so nibble boundaries and the gating of the upper stage are exercised as well as the wraps of the full count. Because the range is only 256 states, directed runs can sweep complete start-offset and end-offset loops several times. Random enables, modes and range values then hit holds that land exactly on the all-ones value and on the end value.

// File: rtl/offset_counter_pkg.sv
package offset_counter_pkg;

  typedef enum logic {
    WRAP_START = 1'b0,
    WRAP_END   = 1'b1
  } wrap_mode_e;

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_p_i,
  input  logic         en_t_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o,
  output logic         rco_o
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] q_q, q_d;

  // clear > load > count
  always_comb begin
    q_d = q_q;
    if (clr_i)                 q_d = '0;
    else if (ld_i)             q_d = ld_val_i;
    else if (en_p_i && en_t_i) q_d = q_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o   = q_q;
  assign rco_o = en_t_i && (q_q == ALL_ONES);

endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import offset_counter_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  wrap_mode_e   mode_i,
  input  logic         en_p_i,
  input  logic         en_t_i,
  input  logic         carry_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] end_val_i,
  output logic         clr_o,
  output logic         ld_o
);

  logic run;
  logic end_hit;

  assign run     = en_p_i && en_t_i;
  assign end_hit = (count_i == end_val_i);

  // carry already includes en_t; en_p added so a held count never reloads
  assign ld_o  = (mode_i == WRAP_START) && carry_i && en_p_i;
  assign clr_o = (mode_i == WRAP_END) && end_hit && run;

endmodule

// File: rtl/offset_counter.sv
module offset_counter
  import offset_counter_pkg::*;
#(
  parameter int unsigned STAGE_W    = 4,
  parameter int unsigned NUM_STAGES = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_p_i,
  input  logic                          en_t_i,
  input  logic                          mode_i,
  input  logic [STAGE_W*NUM_STAGES-1:0] start_val_i,
  input  logic [STAGE_W*NUM_STAGES-1:0] end_val_i,
  output logic [STAGE_W*NUM_STAGES-1:0] count_o,
  output logic                          carry_o
);

  localparam int unsigned CNT_W = STAGE_W * NUM_STAGES;

  logic [NUM_STAGES:0] t_chain;
  logic [CNT_W-1:0]    count;
  logic                clr, ld;
  wrap_mode_e          mode;

  assign mode       = wrap_mode_e'(mode_i);
  assign t_chain[0] = en_t_i;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_p_i   (en_p_i),
      .en_t_i   (t_chain[s]),
      .clr_i    (clr),
      .ld_i     (ld),
      .ld_val_i (start_val_i[s*STAGE_W +: STAGE_W]),
      .q_o      (count[s*STAGE_W +: STAGE_W]),
      .rco_o    (t_chain[s+1])
    );
  end

  wrap_ctrl #(.W(CNT_W)) u_wrap (
    .mode_i    (mode),
    .en_p_i    (en_p_i),
    .en_t_i    (en_t_i),
    .carry_i   (t_chain[NUM_STAGES]),
    .count_i   (count),
    .end_val_i (end_val_i),
    .clr_o     (clr),
    .ld_o      (ld)
  );

  assign count_o = count;
  assign carry_o = t_chain[NUM_STAGES];

endmodule

module offset_counter_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_p_i,
  input logic         en_t_i,
  input logic         mode_i,
  input logic [W-1:0] start_val_i,
  input logic [W-1:0] end_val_i,
  input logic [W-1:0] count_o,
  input logic         carry_o
);

  localparam logic [W-1:0] MAX = {W{1'b1}};

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_p_i && en_t_i) |=> $stable(count_o));

  // R4
  carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == (en_t_i && count_o == MAX));

  // R5
  start_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && en_p_i && en_t_i && count_o == MAX) |=> count_o == $past(start_val_i));

  // R6
  end_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && en_p_i && en_t_i && count_o == end_val_i) |=> count_o == '0);

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_p_i && en_t_i && count_o != MAX && !(mode_i && count_o == end_val_i))
    |=> count_o == $past(count_o) + W'(1));

endmodule

bind offset_counter offset_counter_chk #(.W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_p_i      (en_p_i),
  .en_t_i      (en_t_i),
  .mode_i      (mode_i),
  .start_val_i (start_val_i),
  .end_val_i   (end_val_i),
  .count_o     (count_o),
  .carry_o     (carry_o)
);

// File: tb/offset_counter_tb.sv
module offset_counter_tb;

  localparam int unsigned SW = 4;
  localparam int unsigned NS = 2;
  localparam int unsigned W  = SW * NS;
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_p_i = 1'b0, en_t_i = 1'b0, mode_i = 1'b0;
  logic [W-1:0] start_val_i = '0, end_val_i = '0;
  logic [W-1:0] count_o;
  logic         carry_o;

  int unsigned n_vec = 0;
  int unsigned n_err = 0;
  logic [W-1:0] exp_cnt = '0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  offset_counter #(.STAGE_W(SW), .NUM_STAGES(NS)) u_dut (
    .clk_i, .rst_ni, .en_p_i, .en_t_i, .mode_i,
    .start_val_i, .end_val_i, .count_o, .carry_o
  );

  function automatic logic [W-1:0] model(logic [W-1:0] c, logic p, logic t,
                                         logic m, logic [W-1:0] sv, logic [W-1:0] ev);
    if (!(p && t))            return c;
    if (!m && c == MAX)       return sv;
    if (m && c == ev)         return '0;
    return c + W'(1);
  endfunction

  function automatic string tag(logic [W-1:0] c, logic p, logic t,
                                logic m, logic [W-1:0] sv, logic [W-1:0] ev);
    if (!(p && t))                 return "R3";
    if (!m && c == MAX)            return "R5";
    if (m && c == ev)              return "R6";
    if (c[SW-1:0] == {SW{1'b1}})   return "R7";
    if ((!m && c < sv) || (m && c > ev)) return "R8";
    return "R2";
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; applies inputs for one edge and checks the outcome
  task automatic cyc(logic p, logic t, logic m, logic [W-1:0] sv, logic [W-1:0] ev);
    string r;
    logic [W-1:0] nxt;
    en_p_i = p; en_t_i = t; mode_i = m; start_val_i = sv; end_val_i = ev;
    #1;
    chk("R4", {{(W-1){1'b0}}, carry_o}, {{(W-1){1'b0}}, (t && exp_cnt == MAX)});
    r   = tag(exp_cnt, p, t, m, sv, ev);
    nxt = model(exp_cnt, p, t, m, sv, ev);
    @(negedge clk_i);
    exp_cnt = nxt;
    chk(r, count_o, exp_cnt);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R1", count_o, '0);
    rst_ni = 1'b1;
    exp_cnt = '0;

    // start-offset loops from 0x06
    for (int i = 0; i < 520; i++) cyc(1, 1, 0, 8'h06, 8'h00);
    // hold at all ones: P low (carry stays high), then T low
    while (exp_cnt != MAX) cyc(1, 1, 0, 8'h06, 8'h00);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 8'h06, 8'h00);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h06, 8'h00);
    cyc(0, 0, 0, 8'h06, 8'h00);
    cyc(1, 1, 0, 8'h06, 8'h00);

    // end-offset loops ending at 0x0D
    for (int i = 0; i < 300; i++) cyc(1, 1, 1, 8'h00, 8'h0D);
    while (exp_cnt != 8'h0D) cyc(1, 1, 1, 8'h00, 8'h0D);
    for (int i = 0; i < 2; i++) cyc(0, 1, 1, 8'h00, 8'h0D);
    cyc(1, 0, 1, 8'h00, 8'h0D);
    cyc(1, 1, 1, 8'h00, 8'h0D);
    // end value all ones and start value zero: plain rollover
    for (int i = 0; i < 270; i++) cyc(1, 1, 1, 8'h00, MAX);
    for (int i = 0; i < 270; i++) cyc(1, 1, 0, 8'h00, 8'h00);
    // end value above count after mode switch
    for (int i = 0; i < 40; i++) cyc(1, 1, 1, 8'h00, 8'hF0);

    // random phase
    begin
      logic m;
      logic [W-1:0] sv, ev;
      m = 1'b0; sv = 8'hE0; ev = 8'h20;
      for (int i = 0; i < 3000; i++) begin
        if (i % 97 == 0) begin
          m  = 1'($urandom_range(0, 1));
          sv = W'($urandom_range(8'hC0, 8'hFE));
          ev = W'($urandom_range(8'h02, 8'h30));
        end
        cyc($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0, m, sv, ev);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule